// File: doc/BRIEF.md
# UART Register Front-End With Receive Buffer

This block is the software-visible side of a UART on a 32-bit memory-mapped bus. It holds the data, flag, control, line-control, baud divisor, IrDA low-power divisor, FIFO level select, interrupt mask, raw and masked interrupt status, interrupt clear and DMA control registers. It also answers a read-only identification region at the top of its 4 KiB window. The serializer, the deserializer, the baud generator and the DMA handshake sit outside the block. The divisor registers, the DMA control and the IrDA register are plain storage.

A write to the data register places one byte on a valid/ready transmit stream and raises the transmit interrupt. Received bytes arrive on a valid/ready stream and enter a circular buffer. The buffer holds 16 bytes when the FIFO enable bit of line control is set and one byte when it is clear. Reads of the data register take bytes out in arrival order. Receive full, receive empty and the receive interrupt follow the buffer occupancy. The receive interrupt uses a trigger level of one byte. A single interrupt output is high while any unmasked raw interrupt is set.

Bus reads are combinational from the current state, and the read side effect takes place at the clock edge on which `bus_req` is high. A data register read with `bus_req` high removes one byte at that edge.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the flag register (word offset 0x18) reads 0x90, the control register (0x30) reads 0x300, the FIFO level select register (0x34) reads 0x12, and `irq` is low.
- R2: The integer baud register (0x24) holds a written 16-bit value and returns it on read. The other storage registers hold their written values in the same way.
- R3: A write to the data register (0x00) presents the low byte on `tx_data` with `tx_valid` high. It also sets raw interrupt bit 5. The byte is held until `tx_ready` is seen. Flag bit 5 (transmit full) equals `tx_valid`, and flag bit 7 (transmit empty) is its inverse.
- R4: With line-control bit 4 set, up to 16 received bytes are accepted. They are read back from 0x00 in arrival order.
- R5: `rx_ready` is low whenever the buffer holds its current limit: 16 bytes with line-control bit 4 set, or 1 byte with it clear.
- R6: Flag bit 4 (receive empty) is set exactly while the buffer holds no byte.
- R7: Raw interrupt bit 4 is set when the count reaches one byte. It is cleared by a data read that empties the buffer.
- R8: The masked status (0x40) equals the raw status (0x3C) ANDed with the mask (0x38). `irq` is high exactly when the masked status is non-zero.
- R9: A write to the clear register (0x44) clears each raw bit that is set in the written value.
- R10: Reads from 0xFE0 through 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, one byte per word.
- R11: A data read while the buffer is empty returns the byte most recently taken out. It leaves the buffer occupancy unchanged.
- R12: Flag bit 6 (receive full) is set when an arriving byte brings the count to 16, or on any arrival while control bit 4 is set.
- R13: A data register read clears flag bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmit byte taken |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Buffer can accept a byte |
| irq | output | 1 | Combined interrupt |

## Verification
The receive path is tried with three kinds of traffic: a burst that fills the 16-entry buffer and drains it, single-byte traffic with the FIFO disabled, and a seeded random mix of arrivals, reads and FIFO-enable toggles. The fill-and-drain burst separates correct pointer wrap and ordering from off-by-one limits. The single-byte traffic shows that the depth limit follows line control. The random mix, compared against a queue model, catches read-while-arriving and empty-read cases that directed runs miss. The flag, interrupt and identification reads are checked against fixed values derived from the bit positions stated in the requirements.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DEPTH = 16,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int WW = AW - 2;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] TRIG = CW'(1);

  localparam logic [WW-1:0] W_DR   = WW'(0);
  localparam logic [WW-1:0] W_FR   = WW'(6);
  localparam logic [WW-1:0] W_ILP  = WW'(8);
  localparam logic [WW-1:0] W_IBD  = WW'(9);
  localparam logic [WW-1:0] W_FBD  = WW'(10);
  localparam logic [WW-1:0] W_LCR  = WW'(11);
  localparam logic [WW-1:0] W_CR   = WW'(12);
  localparam logic [WW-1:0] W_LVL  = WW'(13);
  localparam logic [WW-1:0] W_MSK  = WW'(14);
  localparam logic [WW-1:0] W_RAW  = WW'(15);
  localparam logic [WW-1:0] W_MST  = WW'(16);
  localparam logic [WW-1:0] W_CLR  = WW'(17);
  localparam logic [WW-1:0] W_DMA  = WW'(18);

  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] rx_count, count_nx, limit;
  logic [7:0]  ilp_q, lcr_q;
  logic [15:0] ibd_q, cr_q;
  logic [5:0]  fbd_q, lvl_q;
  logic [10:0] msk_q;
  logic [2:0]  dma_q;
  logic        rx_ris, tx_ris, rxff_q;

  wire [WW-1:0] widx   = bus_addr[AW-1:2];
  wire          wr     = bus_req & bus_we;
  wire          rd     = bus_req & ~bus_we;
  wire          wr_dr  = wr && widx == W_DR;
  wire          rd_dr  = rd && widx == W_DR;
  wire          wr_clr = wr && widx == W_CLR;
  wire          fifo_en = lcr_q[4];
  wire          push   = rx_valid & rx_ready;
  wire          pop    = rd_dr && rx_count != '0;
  wire [PW-1:0] wr_ptr = rd_ptr + rx_count[PW-1:0];
  wire [1:0]    mis    = {tx_ris & msk_q[5], rx_ris & msk_q[4]};

  assign limit    = fifo_en ? FULL : CW'(1);
  assign rx_ready = rx_count < limit;
  assign count_nx = rx_count + CW'(push) - CW'(pop);
  assign irq      = |mis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wr_ptr] <= rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rx_count <= '0;
      rxff_q   <= 1'b0;
      rx_ris   <= 1'b0;
    end else begin
      rx_count <= count_nx;
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      if (push && (count_nx == FULL || cr_q[4])) rxff_q <= 1'b1;
      else if (rd_dr)                            rxff_q <= 1'b0;
      if (push && count_nx == TRIG)                                      rx_ris <= 1'b1;
      else if ((pop && count_nx == TRIG - CW'(1)) || (wr_clr && bus_wdata[4])) rx_ris <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_ris   <= 1'b0;
    end else begin
      if (wr_dr) begin
        tx_data  <= bus_wdata[7:0];
        tx_valid <= 1'b1;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (wr_dr)                        tx_ris <= 1'b1;
      else if (wr_clr && bus_wdata[5])  tx_ris <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilp_q <= '0;
      ibd_q <= '0;
      fbd_q <= '0;
      lcr_q <= '0;
      cr_q  <= 16'h0300;
      lvl_q <= 6'h12;
      msk_q <= '0;
      dma_q <= '0;
    end else if (wr) begin
      case (widx)
        W_ILP: ilp_q <= bus_wdata[7:0];
        W_IBD: ibd_q <= bus_wdata[15:0];
        W_FBD: fbd_q <= bus_wdata[5:0];
        W_LCR: lcr_q <= bus_wdata[7:0];
        W_CR:  cr_q  <= bus_wdata[15:0];
        W_LVL: lvl_q <= bus_wdata[5:0];
        W_MSK: msk_q <= bus_wdata[10:0];
        W_DMA: dma_q <= bus_wdata[2:0];
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  wire [7:0] rx_head = (rx_count == '0) ? mem[rd_ptr - PW'(1)] : mem[rd_ptr];
  wire [7:0] flags   = {~tx_valid, rxff_q, tx_valid, rx_count == '0, 4'b0};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1:5] == '1) begin
      bus_rdata = {24'b0, id_byte(bus_addr[4:2])};
    end else begin
      case (widx)
        W_DR:  bus_rdata = {24'b0, rx_head};
        W_FR:  bus_rdata = {24'b0, flags};
        W_ILP: bus_rdata = {24'b0, ilp_q};
        W_IBD: bus_rdata = {16'b0, ibd_q};
        W_FBD: bus_rdata = {26'b0, fbd_q};
        W_LCR: bus_rdata = {24'b0, lcr_q};
        W_CR:  bus_rdata = {16'b0, cr_q};
        W_LVL: bus_rdata = {26'b0, lvl_q};
        W_MSK: bus_rdata = {21'b0, msk_q};
        W_RAW: bus_rdata = {26'b0, tx_ris, rx_ris, 4'b0};
        W_MST: bus_rdata = {26'b0, mis, 4'b0};
        W_DMA: bus_rdata = {29'b0, dma_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          irq,
  input logic [$clog2(DEPTH):0] count,
  input logic          fen,
  input logic          ris_rx,
  input logic          ris_tx
);
  wire wr_dr  = bus_req && bus_we && bus_addr[AW-1:2] == '0;
  wire rd_dr  = bus_req && !bus_we && bus_addr[AW-1:2] == '0;
  wire wr_clr = bus_req && bus_we && bus_addr[AW-1:2] == (AW-2)'(17);
  wire push   = rx_valid && rx_ready;

  assert_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_single_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fen && count != '0) |-> !rx_ready);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_dr) |=> (tx_valid && $stable(tx_data)));

  assert_tx_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dr |=> ris_tx);

  assert_clear_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[4] && !push) |=> !ris_rx);

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dr && count == '0 && !push) |=> count == '0);
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .irq(irq), .count(rx_count), .fen(fifo_en),
  .ris_rx(rx_ris), .ris_tx(tx_ris)
);

// File: tb/uart_regfront_test.sv
module uart_regfront_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;

  int n_run = 0, n_fail = 0;
  bit fen = 0;
  logic [7:0] q[$];
  logic [7:0] last_pop = 8'h00;

  uart_regfront uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(input int k);
    logic [63:0] v = 64'h1110_1400_0DF0_05B1;
    return v[63-8*k -: 8];
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_req = 0;
  endtask

  task automatic rd_data(input string tag);
    logic [31:0] d;
    logic [7:0] e;
    if (q.size() > 0) begin e = q.pop_front(); last_pop = e; end
    else e = last_pop;
    rd(12'h000, d);
    check(tag, d, {24'b0, e});
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    bit exp_rdy;
    exp_rdy = q.size() < (fen ? 16 : 1);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #1 check(tag, {31'b0, rx_ready}, {31'b0, exp_rdy});
    @(posedge clk); #1 rx_valid = 0;
    if (exp_rdy) q.push_back(b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(12'h018, d); check("R1 flags", d, 32'h90);
    rd(12'h030, d); check("R1 control", d, 32'h300);
    rd(12'h034, d); check("R1 level", d, 32'h12);
    check("R1 irq", {31'b0, irq}, 0);

    wr(12'h024, 32'h1234); rd(12'h024, d); check("R2 ibrd", d, 32'h1234);
    wr(12'h020, 32'h5A);   rd(12'h020, d); check("R2 ilpr", d, 32'h5A);

    wr(12'h000, 32'hA5);
    check("R3 valid", {31'b0, tx_valid}, 1);
    check("R3 data", {24'b0, tx_data}, 32'hA5);
    rd(12'h018, d); check("R3 flags busy", d, 32'h30);
    rd(12'h03C, d); check("R3 raw tx", d, 32'h20);
    @(negedge clk) tx_ready = 1;
    @(posedge clk); #1 tx_ready = 0;
    check("R3 taken", {31'b0, tx_valid}, 0);
    wr(12'h044, 32'h20); rd(12'h03C, d); check("R9 clear tx", d, 32'h0);

    wr(12'h02C, 32'h10); fen = 1;
    wr(12'h038, 32'h30);
    push(8'h40, "R4 accept");
    rd(12'h03C, d); check("R7 raw rx", d, 32'h10);
    rd(12'h040, d); check("R8 masked", d, 32'h10);
    check("R8 irq", {31'b0, irq}, 1);
    for (int i = 1; i < 16; i++) push(8'h40 + 8'(i), "R4 accept");
    check("R5 full", {31'b0, rx_ready}, 0);
    push(8'hEE, "R5 refused");
    rd(12'h018, d); check("R12 full flag", d, 32'hC0);
    rd_data("R4 order");
    rd(12'h018, d); check("R13 cleared", d, 32'h80);
    for (int i = 1; i < 16; i++) rd_data("R4 order");
    rd(12'h03C, d); check("R7 drained", d, 32'h0);
    check("R8 irq low", {31'b0, irq}, 0);
    rd(12'h018, d); check("R6 empty", d, 32'h90);

    rd_data("R11 empty read");
    rd(12'h018, d); check("R11 still empty", d, 32'h90);
    push(8'h77, "R11 push");
    rd(12'h018, d); check("R6 not empty", d, 32'h80);
    wr(12'h038, 32'h10); wr(12'h044, 32'h10);
    rd(12'h03C, d); check("R9 clear rx", d, 32'h0);
    rd_data("R11 after empty");

    wr(12'h02C, 32'h00); fen = 0;
    push(8'h21, "R5 single");
    check("R5 limit", {31'b0, rx_ready}, 0);
    push(8'h22, "R5 refused");
    rd_data("R5 byte");

    wr(12'h030, 32'h310);
    push(8'h33, "R12 push");
    rd(12'h018, d); check("R12 forced", d, 32'hC0);
    rd_data("R12 byte");
    wr(12'h030, 32'h300);

    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4*i), d);
      check("R10 id", d, {24'b0, exp_id(i)});
    end

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) push(8'($urandom), "R4 random push");
      else if (op < 9) rd_data("R4 random read");
      else begin
        fen = ~fen;
        wr(12'h02C, fen ? 32'h10 : 32'h0);
        rd(12'h018, d);
        check("R6 random", {31'b0, d[4]}, {31'b0, q.size() == 0});
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule